// File: doc/BRIEF.md
# Serial Command Character Bridge

This block is a slave on a chip-selected synchronous serial bus. It gives a host a two-way character channel. The host exchanges 16-bit frames with the slave, most significant bit first. The first four bits of each frame are a command. The slave decodes that command as soon as the fourth bit arrives. It then shifts reply bits back for the rest of the same full-duplex frame.

Five commands are understood:
- an identity probe, which a host uses to detect that the device is present;
- a transmit-space query;
- a character send;
- a receive-data query;
- a character fetch.

Behind the bridge are two character FIFOs. One carries characters from the host to a transmit stream. The other collects characters from a receive stream for the host to fetch. The far ends of both FIFOs are plain valid/ready interfaces, so a UART or USB-side model can be attached.

The serial interface is sampled in the block's clock domain. `ser_stb` is a one-cycle strobe that marks the clock in which `ser_din` holds the next frame bit. `ser_dout` is a registered output. It shows the reply bit for the frame position that the next strobe will consume.

Top module: `serial_char_bridge`

## Requirements
- R1: While `ser_sel` is high, each `ser_stb` consumes one bit of `ser_din`. Frame bit 15 comes first and bit 0 last, so frame bit n corresponds to bit n+16 of a 32-bit left-justified word. Frame bits 15:12 form the command. Before each strobe, `ser_dout` holds the reply bit for the position that strobe consumes. Reply bits 15:12 are always 0.
- R2: Command 0x9 returns the reply 0x0470.
- R3: Command 0xC returns 0x0400 (bit 10 set) when the transmit FIFO can take a character, and 0x0000 when it is full.
- R4: Command 0xB takes the character in frame bits 11:4. At the end of the frame it pushes that character into the transmit FIFO. The reply is 0x0000.
- R5: Command 0xD returns 0x0400 when the receive FIFO holds at least one character, and 0x0000 otherwise.
- R6: Command 0xA with data waiting returns bit 11 set and the oldest received character in bits 7:0, and pops that character when the frame completes. With the receive FIFO empty it returns 0x0000 and pops nothing.
- R7: When `ser_sel` goes low, the bit counter resets and `ser_dout` reads 0 from the next cycle on. A partial frame has no FIFO side effect. The next selected frame starts again at frame bit 15.
- R8: A send command that completes while the transmit FIFO is full leaves the FIFO contents unchanged.
- R9: Any other command code returns 0x0000 and changes neither FIFO.
- R10: Both FIFOs hold 16 characters and keep them in order. `tx_valid` and `tx_data` stay stable until `tx_ready` is high. `rx_ready` is low exactly when the receive FIFO is full.
- R11: After reset, `ser_dout` and `tx_valid` are 0 and `rx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_sel | input | 1 | Chip select, high while a frame is in progress |
| ser_stb | input | 1 | One-cycle strobe marking a valid frame bit |
| ser_din | input | 1 | Serial data from host |
| ser_dout | output | 1 | Serial reply bit to host |
| tx_data | output | 8 | Head character of the transmit FIFO |
| tx_valid | output | 1 | Transmit FIFO not empty |
| tx_ready | input | 1 | Consumer takes `tx_data` when high with `tx_valid` |
| rx_data | input | 8 | Received character from the line side |
| rx_valid | input | 1 | `rx_data` is offered |
| rx_ready | output | 1 | Receive FIFO has space |

## Verification
A bit counter that is off by one shows up within the same frame: every reply after the command would be shifted by a bit position. The identity reply stops reading 0x0470, and the send character lands in the wrong bits. A stale or wrong FIFO occupancy appears in the very next query frame as a wrong bit 10. It also appears at the stream ports as a wrong character order or a missing character when the FIFO is drained. A side effect that fires on an aborted frame shows up straight after the deselect, as `tx_valid` rising or a fetched character being lost.

// File: rtl/scb_pkg.sv
package scb_pkg;
  localparam logic [3:0] CMD_IDENT = 4'h9;
  localparam logic [3:0] CMD_FETCH = 4'hA;
  localparam logic [3:0] CMD_SEND  = 4'hB;
  localparam logic [3:0] CMD_TXQ   = 4'hC;
  localparam logic [3:0] CMD_RXQ   = 4'hD;
  // reply bits after the command nibble (frame bits 11:0)
  localparam logic [11:0] IDENT_TAIL = 12'h470;
endpackage

// File: rtl/scb_char_fifo.sv
module scb_char_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          full,
  output logic          empty,
  output logic [AW:0]   count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (count == (AW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/scb_serial_frame.sv
module scb_serial_frame #(
  parameter int FRAME_W = 16,
  parameter int CMD_W   = 4,
  parameter int CHAR_W  = 8,
  localparam int RW     = FRAME_W - CMD_W,
  localparam int CW     = $clog2(FRAME_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              stb,
  input  logic              din,
  input  logic [RW-1:0]     reply,
  output logic              dout,
  output logic              decode_pulse,
  output logic [CMD_W-1:0]  cmd_now,
  output logic              done_pulse,
  output logic [CHAR_W-1:0] frame_char
);
  logic [CW-1:0] cnt;
  logic [RW-2:0] sh;
  logic [RW-1:0] sh_next;
  logic [RW-2:0] rep;

  assign sh_next      = {sh, din};
  assign decode_pulse = sel && stb && (cnt == CW'(CMD_W-1));
  assign done_pulse   = sel && stb && (cnt == CW'(FRAME_W-1));
  assign cmd_now      = sh_next[CMD_W-1:0];
  assign frame_char   = sh_next[RW-1 -: CHAR_W];

  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      cnt  <= '0;
      dout <= 1'b0;
      rep  <= '0;
    end else if (stb) begin
      cnt <= done_pulse ? '0 : cnt + 1'b1;
      if (decode_pulse) begin
        dout <= reply[RW-1];
        rep  <= reply[RW-2:0];
      end else if (cnt >= CW'(CMD_W) && cnt <= CW'(FRAME_W-2)) begin
        dout <= rep[RW-2];
        rep  <= {rep[RW-3:0], 1'b0};
      end else begin
        dout <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (sel && stb) sh <= sh_next[RW-2:0];
  end
endmodule

// File: rtl/serial_char_bridge.sv
module serial_char_bridge
  import scb_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_sel,
  input  logic              ser_stb,
  input  logic              ser_din,
  output logic              ser_dout,
  output logic [CHAR_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              rx_ready
);
  localparam int FRAME_W = 16;
  localparam int CMD_W   = 4;
  localparam int RW      = FRAME_W - CMD_W;

  logic              decode_pulse, done_pulse;
  logic [CMD_W-1:0]  cmd_now, cmd_q;
  logic [CHAR_W-1:0] frame_char, rx_head;
  logic [RW-1:0]     reply;
  logic              hit_q;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [AW:0]       tx_cnt, rx_cnt;
  logic              tx_push, rx_pop;

  scb_serial_frame #(.FRAME_W(FRAME_W), .CMD_W(CMD_W), .CHAR_W(CHAR_W)) u_frame (
    .clk(clk), .rst(rst), .sel(ser_sel), .stb(ser_stb), .din(ser_din),
    .reply(reply), .dout(ser_dout), .decode_pulse(decode_pulse),
    .cmd_now(cmd_now), .done_pulse(done_pulse), .frame_char(frame_char)
  );

  always_comb begin
    reply = '0;
    case (cmd_now)
      CMD_IDENT: reply = IDENT_TAIL;
      CMD_TXQ:   reply[RW-2] = !tx_full;
      CMD_RXQ:   reply[RW-2] = !rx_empty;
      CMD_FETCH: begin
        reply[RW-1]       = !rx_empty;
        reply[CHAR_W-1:0] = rx_empty ? '0 : rx_head;
      end
      default:   reply = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      hit_q <= 1'b0;
    end else if (decode_pulse) begin
      cmd_q <= cmd_now;
      hit_q <= (cmd_now == CMD_FETCH) && !rx_empty;
    end
  end

  assign tx_push = done_pulse && (cmd_q == CMD_SEND) && !tx_full;
  assign rx_pop  = done_pulse && hit_q;

  scb_char_fifo #(.DW(CHAR_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(tx_push), .din(frame_char),
    .pop(tx_ready), .dout(tx_data), .full(tx_full), .empty(tx_empty),
    .count(tx_cnt)
  );

  scb_char_fifo #(.DW(CHAR_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_valid), .din(rx_data),
    .pop(rx_pop), .dout(rx_head), .full(rx_full), .empty(rx_empty),
    .count(rx_cnt)
  );

  assign tx_valid = !tx_empty;
  assign rx_ready = !rx_full;
endmodule

// File: rtl/serial_char_bridge_chk.sv
module serial_char_bridge_chk #(
  parameter int CHAR_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst,
  input logic              ser_sel,
  input logic              ser_dout,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [CHAR_W-1:0] tx_data,
  input logic [AW:0]       tx_cnt,
  input logic [AW:0]       rx_cnt
);
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ser_sel |=> !ser_dout); // R7
  AST_TX_BOUND: assert property (@(posedge clk) disable iff (rst)
    tx_cnt <= (AW+1)'(DEPTH)); // R10
  AST_RX_BOUND: assert property (@(posedge clk) disable iff (rst)
    rx_cnt <= (AW+1)'(DEPTH)); // R10
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R10
  AST_TX_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (tx_cnt == (AW+1)'(DEPTH) && !tx_ready) |=> (tx_cnt == (AW+1)'(DEPTH))); // R8
endmodule

bind serial_char_bridge serial_char_bridge_chk #(.CHAR_W(CHAR_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .ser_sel(ser_sel), .ser_dout(ser_dout),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/sim_serial_char_bridge.sv
module sim_serial_char_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_sel = 1'b0, ser_stb = 1'b0, ser_din = 1'b0;
  logic ser_dout;
  logic [7:0] tx_data;
  logic tx_valid;
  logic tx_ready = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic rx_valid = 1'b0;
  logic rx_ready;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [7:0] txm[$];
  logic [7:0] rxm[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_char_bridge u0 (
    .clk(clk), .rst(rst), .ser_sel(ser_sel), .ser_stb(ser_stb), .ser_din(ser_din),
    .ser_dout(ser_dout), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_reply(input logic [3:0] c);
    case (c)
      4'h9: return 16'h0470;
      4'hC: return (txm.size() < DEPTH) ? 16'h0400 : 16'h0000;
      4'hD: return (rxm.size() > 0) ? 16'h0400 : 16'h0000;
      4'hA: return (rxm.size() > 0) ? {8'h08, rxm[0]} : 16'h0000;
      default: return 16'h0000;
    endcase
  endfunction

  // shift nbits of w (from bit 15 down); returns reply bits seen
  task automatic shift_bits(input logic [15:0] w, input int nbits, output logic [15:0] r);
    r = '0;
    @(negedge clk) ser_sel = 1'b1;
    for (int k = 0; k < nbits; k++) begin
      @(negedge clk);
      ser_din = w[15-k];
      r[15-k] = ser_dout;
      ser_stb = 1'b1;
      @(negedge clk) ser_stb = 1'b0;
    end
    @(negedge clk) ser_sel = 1'b0;
    @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] w, input string req);
    logic [15:0] r, e;
    e = model_reply(w[15:12]);
    shift_bits(w, 16, r);
    chk(r === e, req, r, e);
    if (w[15:12] == 4'hB && txm.size() < DEPTH) txm.push_back(w[11:4]);
    if (w[15:12] == 4'hA && rxm.size() > 0) void'(rxm.pop_front());
  endtask

  task automatic rx_push(input logic [7:0] d);
    @(negedge clk);
    chk(rx_ready === (rxm.size() < DEPTH), "R10 rx_ready", {15'd0, rx_ready}, {15'd0, rxm.size() < DEPTH});
    rx_data = d; rx_valid = 1'b1;
    @(negedge clk) rx_valid = 1'b0;
    if (rxm.size() < DEPTH) rxm.push_back(d);
  endtask

  task automatic tx_take(input string req);
    @(negedge clk);
    chk(tx_valid === (txm.size() > 0), req, {15'd0, tx_valid}, {15'd0, txm.size() > 0});
    if (txm.size() > 0) begin
      chk(tx_data === txm[0], req, {8'd0, tx_data}, {8'd0, txm[0]});
      void'(txm.pop_front());
    end
    tx_ready = 1'b1;
    @(negedge clk) tx_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(ser_dout === 1'b0 && tx_valid === 1'b0 && rx_ready === 1'b1, "R11 reset",
        {13'd0, ser_dout, tx_valid, rx_ready}, 16'h0001);
    rst = 1'b0;
    @(negedge clk);

    frame(16'h9000, "R2 identify");
    frame(16'h9ABC, "R2 identify with junk bits R1");
    frame(16'hC000, "R3 tx space empty");
    frame(16'hD000, "R5 rx empty");
    frame(16'hA000, "R6 fetch empty");

    // fill tx, then overflow
    for (int i = 0; i < DEPTH; i++) frame({4'hB, 8'(8'h30 + i), 4'h0}, "R4 send");
    frame(16'hC000, "R3 tx full");
    frame({4'hB, 8'hEE, 4'h5}, "R8 send while full");
    for (int i = 0; i < DEPTH + 1; i++) tx_take("R10 R8 tx order");

    // fill rx and fetch back
    for (int i = 0; i < DEPTH; i++) rx_push(8'(8'hA0 + 3 * i));
    @(negedge clk);
    chk(rx_ready === 1'b0, "R10 rx full", {15'd0, rx_ready}, 16'h0000);
    frame(16'hD000, "R5 rx ready");
    for (int i = 0; i < DEPTH; i++) frame(16'hA000, "R6 fetch");
    frame(16'hA000, "R6 fetch drained");

    // aborted frame
    shift_bits({4'hB, 8'h5A, 4'h0}, 9, r);
    @(negedge clk);
    chk(tx_valid === 1'b0, "R7 partial send discarded", {15'd0, tx_valid}, 16'h0000);
    chk(ser_dout === 1'b0, "R7 dout low deselected", {15'd0, ser_dout}, 16'h0000);
    rx_push(8'h77);
    shift_bits(16'hA000, 14, r);
    frame(16'h9000, "R7 identify after abort");
    frame(16'hD000, "R7 partial fetch kept data");

    // unknown command
    frame({4'h3, 8'h11, 4'h0}, "R9 unknown code");
    frame({4'hF, 8'h22, 4'hF}, "R9 unknown code");
    tx_take("R9 no push");
    frame(16'hD000, "R9 rx unchanged");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [3:0] c;
      case ($urandom_range(0, 7))
        0: c = 4'h9; 1: c = 4'hA; 2: c = 4'hB; 3: c = 4'hC; 4: c = 4'hD;
        5: c = 4'($urandom_range(0, 15));
        6: c = 4'hF;
        default: c = 4'h0;
      endcase
      case ($urandom_range(0, 3))
        0: rx_push(8'($urandom));
        1: tx_take("R10 random drain");
        default: frame({c, 12'($urandom)}, "R1 random frame");
      endcase
    end
    while (txm.size() > 0) tx_take("R4 final drain");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule